// File: doc/BRIEF.md
# Dual-Framing Serial Slave Port

This block is the serial front end of a multi-channel converter that also holds non-volatile settings. A static input, `frame_sel`, picks one of two framings. When it is high, the port uses a 16-bit frame bounded by an active-low chip select, and the same select can instead open a status poll. When it is low, the port takes a 14-bit word that shifts in freely and is committed by a high pulse on the shared select/load pin. In both framings one shift register holds the incoming word. When a frame is accepted, the port hands the word to the downstream decoder or data register through a one-cycle strobe.

All serial pins are asynchronous to the system clock. They pass through two-flop synchronizers, and their edges are found in the system clock domain. `busy_in` comes from the downstream write logic on the system clock. The port reports it as a Ready/Busy level on the serial output, with 1 for ready and 0 for busy.

Top module: `dual_frame_serial_port`

## Requirements
- R1: After reset, `sdo_oe` is 0 while `frame_sel` is 1, `sdo_out` is 0 and `xfer_valid` is 0.
- R2: Input bits are taken from `sdi_in` on rising `sclk_in` edges. In 16-bit framing the first bit received becomes bit 0 of the word.
- R3: In 14-bit framing the first bit received becomes bit 13 of the word. A committed word has bits 15 and 14 equal to 0.
- R4: In 16-bit data mode `sdo_out` changes only after falling `sclk_in` edges. Once the select has fallen, the i-th falling edge (counting from 0) presents bit i of the previous register contents, so the old contents leave LSB first.
- R5: In 14-bit framing with `sclk_in` idling high, the i-th falling edge presents bit 13−i of the previous register contents, so the old contents leave MSB first.
- R6: In 16-bit framing, `sdo_oe` is 0 whenever the select is high. A select fall while `sclk_in` is high opens data mode, and in data mode `sdo_oe` is 1.
- R7: In 16-bit framing, a select fall while `sclk_in` is low opens status mode. In status mode `sdo_oe` is 1 and `sdo_out` follows `busy_in` inverted (1 ready, 0 busy).
- R8: A rising select ends status mode at any clock level, sets `sdo_oe` to 0 and produces no strobe.
- R9: In 16-bit framing, a strobe fires on the rising select only when exactly 16 bits were received in data mode. Frames of 15 or 17 bits are dropped.
- R10: In 14-bit framing, `sdo_oe` stays 1 and every rising edge on the load pin commits the register. While `busy_in` is 1, `sdo_out` is held at 0.
- R11: `xfer_valid` is high for exactly one system clock cycle per accepted frame. Port reactions appear within 4 system clock cycles of the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sel | input | 1 | 1: 16-bit select-framed, 0: 14-bit load-committed |
| sclk_in | input | 1 | Serial clock (asynchronous) |
| sdi_in | input | 1 | Serial data in (asynchronous) |
| csld_in | input | 1 | Select (active low) or load pulse (active high) |
| busy_in | input | 1 | Downstream write in progress |
| sdo_out | output | 1 | Serial data or Ready/Busy level |
| sdo_oe | output | 1 | Output enable for the serial data pin |
| xfer_valid | output | 1 | One-cycle word transfer strobe |
| xfer_word | output | WORD_LONG | Transferred word, 14-bit words zero-extended |

## Verification
The bench builds the port with its defaults: 16 and 14 bit words and two synchronizer stages. With these values the exact-length test sits one bit either side of the 16-bit limit. The padding check on 14-bit words then covers two real bits. A vector table mixes both framings, so each frame also reads back the register contents that the previous framing left behind. Directed tests then cover status polling with a changing busy level, dropped short and long frames, and the busy override in load framing.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  typedef enum logic [1:0] {
    LINK_IDLE = 2'd0,
    LINK_DATA = 2'd1,
    LINK_STAT = 2'd2
  } link_mode_t;
endpackage

// File: rtl/ssi_sync.sv
module ssi_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ssi_frame_ctrl.sv
module ssi_frame_ctrl
  import ssi_pkg::*;
#(
  parameter int WORD_LONG = 16,
  localparam int CNT_W    = $clog2(WORD_LONG + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_sel,
  input  logic             sclk_s,
  input  logic             csld_s,
  output link_mode_t       mode_q,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             shift_en,
  output logic             out_step,
  output logic             data_entry,
  output logic             commit,
  output logic             oe_q
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_LONG);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_LONG + 1);

  logic sclk_prev, csld_prev;
  logic sclk_rise, sclk_fall, sel_rise, sel_fall;
  link_mode_t mode_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b1;
      csld_prev <= 1'b1;
    end else begin
      sclk_prev <= sclk_s;
      csld_prev <= csld_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign sclk_fall = ~sclk_s & sclk_prev;
  assign sel_rise  = csld_s & ~csld_prev;
  assign sel_fall  = ~csld_s & csld_prev;

  always_comb begin
    mode_d = mode_q;
    if (!frame_sel) begin
      mode_d = LINK_IDLE;
    end else begin
      case (mode_q)
        LINK_IDLE: if (sel_fall) mode_d = sclk_s ? LINK_DATA : LINK_STAT;
        default:   if (sel_rise) mode_d = LINK_IDLE;
      endcase
    end
  end

  assign data_entry = frame_sel && mode_q == LINK_IDLE && sel_fall && sclk_s;
  assign shift_en   = sclk_rise && (!frame_sel || mode_q == LINK_DATA);
  assign out_step   = sclk_fall && (!frame_sel || mode_q == LINK_DATA);
  assign commit     = frame_sel ? (sel_rise && mode_q == LINK_DATA && bit_cnt == CNT_FULL)
                                : sel_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= LINK_IDLE;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else begin
      mode_q <= mode_d;
      oe_q   <= frame_sel ? (mode_d != LINK_IDLE) : 1'b1;
      if (data_entry)
        bit_cnt <= '0;
      else if (frame_sel && shift_en && bit_cnt != CNT_OVER)
        bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // R6: a select fall with the clock high opens data mode
  a_r6_data_entry: assert property (@(posedge clk) disable iff (rst)
    (frame_sel && mode_q == LINK_IDLE && sel_fall && sclk_s) |=> mode_q == LINK_DATA);

  // R7: a select fall with the clock low opens status mode
  a_r7_stat_entry: assert property (@(posedge clk) disable iff (rst)
    (frame_sel && mode_q == LINK_IDLE && sel_fall && !sclk_s) |=> mode_q == LINK_STAT);
endmodule

// File: rtl/ssi_shifter.sv
module ssi_shifter #(
  parameter int WORD_LONG  = 16,
  parameter int WORD_SHORT = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 long_mode,
  input  logic                 sdi_s,
  input  logic                 shift_en,
  input  logic                 out_step,
  input  logic                 data_entry,
  input  logic                 status_drive,
  input  logic                 busy_in,
  input  logic                 commit,
  output logic                 sdo_q,
  output logic                 xfer_valid_q,
  output logic [WORD_LONG-1:0] xfer_word_q
);
  localparam logic [WORD_LONG-1:0] SHORT_MASK = WORD_LONG'((64'd1 << WORD_SHORT) - 64'd1);

  logic [WORD_LONG-1:0] sr, sr_long_nx, sr_short_nx;

  assign sr_long_nx  = {sdi_s, sr[WORD_LONG-1:1]};
  assign sr_short_nx = (sr & ~SHORT_MASK) | (((sr << 1) | WORD_LONG'(sdi_s)) & SHORT_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr           <= '0;
      sdo_q        <= 1'b0;
      xfer_valid_q <= 1'b0;
      xfer_word_q  <= '0;
    end else begin
      if (shift_en) sr <= long_mode ? sr_long_nx : sr_short_nx;

      if (status_drive)
        sdo_q <= ~busy_in;
      else if (!long_mode && busy_in)
        sdo_q <= 1'b0;
      else if (out_step || data_entry)
        sdo_q <= long_mode ? sr[0] : sr[WORD_SHORT-1];

      xfer_valid_q <= commit;
      if (commit) xfer_word_q <= long_mode ? sr : (sr & SHORT_MASK);
    end
  end

  // R11: the strobe never lasts two cycles
  a_r11_pulse: assert property (@(posedge clk) disable iff (rst)
    xfer_valid_q |=> !xfer_valid_q);
endmodule

// File: rtl/dual_frame_serial_port.sv
module dual_frame_serial_port
  import ssi_pkg::*;
#(
  parameter int WORD_LONG   = 16,
  parameter int WORD_SHORT  = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_sel,
  input  logic                 sclk_in,
  input  logic                 sdi_in,
  input  logic                 csld_in,
  input  logic                 busy_in,
  output logic                 sdo_out,
  output logic                 sdo_oe,
  output logic                 xfer_valid,
  output logic [WORD_LONG-1:0] xfer_word
);
  localparam int CNT_W = $clog2(WORD_LONG + 2);

  logic [2:0]       pins_s;
  link_mode_t       mode_q;
  logic [CNT_W-1:0] bit_cnt;
  logic             shift_en, out_step, data_entry, commit;

  ssi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk (clk), .rst (rst),
    .d   ({sdi_in, csld_in, sclk_in}),
    .q   (pins_s)
  );

  ssi_frame_ctrl #(.WORD_LONG(WORD_LONG)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .frame_sel  (frame_sel),
    .sclk_s     (pins_s[0]),
    .csld_s     (pins_s[1]),
    .mode_q     (mode_q),
    .bit_cnt    (bit_cnt),
    .shift_en   (shift_en),
    .out_step   (out_step),
    .data_entry (data_entry),
    .commit     (commit),
    .oe_q       (sdo_oe)
  );

  ssi_shifter #(.WORD_LONG(WORD_LONG), .WORD_SHORT(WORD_SHORT)) u_shift (
    .clk          (clk),
    .rst          (rst),
    .long_mode    (frame_sel),
    .sdi_s        (pins_s[2]),
    .shift_en     (shift_en),
    .out_step     (out_step),
    .data_entry   (data_entry),
    .status_drive (mode_q == LINK_STAT),
    .busy_in      (busy_in),
    .commit       (commit),
    .sdo_q        (sdo_out),
    .xfer_valid_q (xfer_valid),
    .xfer_word_q  (xfer_word)
  );

  // R6: output released while the select framing is idle
  a_r6_hiz: assert property (@(posedge clk) disable iff (rst)
    (frame_sel && $past(frame_sel) && mode_q == LINK_IDLE) |-> !sdo_oe);

  // R7: status mode reports inverted busy one cycle later
  a_r7_status: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LINK_STAT && $past(mode_q == LINK_STAT)) |-> sdo_out == !$past(busy_in));

  // R9: a select-framed strobe only follows a full-length frame
  a_r9_exact: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && $past(frame_sel)) |-> $past(bit_cnt) == CNT_W'(WORD_LONG));

  // R10: load framing keeps the output driven
  a_r10_oe: assert property (@(posedge clk) disable iff (rst)
    $past(!frame_sel && !rst) |-> sdo_oe);

  // R3: short words arrive zero-extended
  a_r3_pad: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && $past(!frame_sel)) |-> (xfer_word >> WORD_SHORT) == '0);
endmodule

// File: tb/dual_frame_serial_port_test.sv
`timescale 1ns/1ps
module dual_frame_serial_port_test;
  logic clk = 1'b0, rst = 1'b1, frame_sel = 1'b1;
  logic sclk = 1'b1, sdi = 1'b0, csld = 1'b1, busy = 1'b0;
  logic sdo, oe, xv;
  logic [15:0] xw;

  int checks = 0, fails = 0, strobes = 0, cur_w = 0, max_w = 0, cyc = 0;
  logic [15:0] last_word = '0, shadow = '0;
  logic oe_in_frame = 1'b0;

  // {framing select, word}
  localparam logic [16:0] VEC [7] = '{
    {1'b1, 16'hA5C3}, {1'b1, 16'h0001}, {1'b1, 16'h8000},
    {1'b0, 16'h2AAA}, {1'b0, 16'h0001}, {1'b0, 16'h3FFF},
    {1'b1, 16'hFFFF}
  };

  dual_frame_serial_port uut (
    .clk(clk), .rst(rst), .frame_sel(frame_sel), .sclk_in(sclk), .sdi_in(sdi),
    .csld_in(csld), .busy_in(busy), .sdo_out(sdo), .sdo_oe(oe),
    .xfer_valid(xv), .xfer_word(xw)
  );

  always #2 clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (xv) begin
      strobes++; last_word = xw; cur_w++;
      if (cur_w > max_w) max_w = cur_w;
    end else cur_w = 0;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_long(input logic [15:0] w, input int n, input bit check_rd);
    logic [15:0] old;
    int bad;
    old = shadow; bad = 0;
    csld = 1'b0; idle(6);
    oe_in_frame = oe;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; idle(6);
      if (i < 16 && sdo !== old[i]) bad++;
      sdi = w[i % 16]; idle(2);
      sclk = 1'b1;
      shadow = {sdi, shadow[15:1]};
      idle(6);
    end
    csld = 1'b1; idle(6);
    if (check_rd) chk(bad == 0, "R4 LSB-first readout", bad, 0);
  endtask

  task automatic send_short(input logic [13:0] w);
    logic [15:0] old;
    int bad;
    old = shadow; bad = 0;
    for (int i = 0; i < 14; i++) begin
      sclk = 1'b0; idle(6);
      if (sdo !== old[13-i]) bad++;
      sdi = w[13-i]; idle(2);
      sclk = 1'b1;
      shadow[13:0] = {shadow[12:0], sdi};
      idle(6);
    end
    csld = 1'b1; idle(6);
    csld = 1'b0; idle(6);
    chk(bad == 0, "R5 MSB-first readout", bad, 0);
  endtask

  initial begin
    int s0;
    logic [15:0] exp;
    idle(5);
    rst = 1'b0;
    idle(6);
    // R1 reset state
    chk(oe == 1'b0, "R1 oe after reset", oe, 0);
    chk(sdo == 1'b0, "R1 sdo after reset", sdo, 0);
    chk(strobes == 0, "R1 no strobe after reset", strobes, 0);

    // Table walk: R2/R3 word capture, R4/R5 readout of previous contents
    for (int k = 0; k < 7; k++) begin
      if (VEC[k][16] != frame_sel) begin
        if (VEC[k][16]) begin
          frame_sel = 1'b1; idle(4); csld = 1'b1; idle(6);
        end else begin
          frame_sel = 1'b0; idle(2); csld = 1'b0; idle(6);
        end
      end
      s0 = strobes;
      if (VEC[k][16]) begin
        send_long(VEC[k][15:0], 16, 1'b1);
        exp = VEC[k][15:0];
        chk(strobes == s0 + 1 && last_word == exp, "R2 long word capture", last_word, exp);
      end else begin
        send_short(VEC[k][13:0]);
        exp = {2'b00, VEC[k][13:0]};
        chk(strobes == s0 + 1 && last_word == exp, "R3 short word capture", last_word, exp);
      end
    end

    // R6: released when idle, driven in data mode
    chk(oe == 1'b0, "R6 oe idle", oe, 0);
    s0 = strobes;
    send_long(16'h1234, 15, 1'b0);
    chk(strobes == s0, "R9 15-bit frame dropped", strobes - s0, 0);
    chk(oe_in_frame == 1'b1, "R6 oe in data mode", oe_in_frame, 1);
    send_long(16'h4321, 17, 1'b0);
    chk(strobes == s0, "R9 17-bit frame dropped", strobes - s0, 0);
    send_long(16'h0F0F, 16, 1'b1);
    chk(strobes == s0 + 1 && last_word == 16'h0F0F, "R9 exact frame accepted", last_word, 16'h0F0F);

    // R7: status poll
    sclk = 1'b0; idle(6);
    csld = 1'b0; idle(6);
    chk(oe == 1'b1, "R7 oe in status", oe, 1);
    chk(sdo == 1'b1, "R7 ready level", sdo, 1);
    busy = 1'b1; idle(4);
    chk(sdo == 1'b0, "R7 busy level", sdo, 0);
    busy = 1'b0; idle(4);
    chk(sdo == 1'b1, "R7 ready again", sdo, 1);
    // R8: leave status with clock low
    s0 = strobes;
    csld = 1'b1; idle(6);
    chk(oe == 1'b0, "R8 oe released", oe, 0);
    chk(strobes == s0, "R8 no strobe from status", strobes - s0, 0);
    sclk = 1'b1; idle(6);

    // R10: load framing
    frame_sel = 1'b0; idle(2);
    csld = 1'b0; idle(6);
    chk(oe == 1'b1, "R10 oe in load framing", oe, 1);
    busy = 1'b1; idle(4);
    chk(sdo == 1'b0, "R10 busy forces low", sdo, 0);
    busy = 1'b0; idle(2);
    s0 = strobes;
    exp = {2'b00, shadow[13:0]};
    csld = 1'b1; idle(6);
    csld = 1'b0; idle(6);
    chk(strobes == s0 + 1 && last_word == exp, "R10 load commit", last_word, exp);

    // R11: single-cycle strobe
    chk(max_w == 1, "R11 strobe width", max_w, 1);

    summary();
    $finish;
  end
endmodule